// File: doc/BRIEF.md
# Per-Processor Interrupt Pending Word

This block keeps the 32-bit interrupt pending word of one processor. The upper half carries software interrupt requests that the processor raises and drops itself through a small word-addressed register window. The lower half carries hardware interrupt levels, which a system-level controller drives through separate level-set and level-clear strobes. One bit of the lower half is given to a local timer line.

The whole word is visible as a port and through the read path of the window. The software half, moved down by sixteen places, forms a 16-bit level vector. That vector always reaches the processor, whatever masking the system controller applies to its own sources. The block does not prioritise, does not encode a vector and does not take an acknowledge. It only holds, merges and exposes the pending state.

Top module: `intpend_top`

## Requirements
- R1: A read at word offset 0 returns the full pending word on `busRdData`. A read at any other offset returns zero. The read path is combinational from `busAddr`.
- R2: A write at word offset 1 clears each pending bit in positions 31:17 whose written bit is 1. Written bits outside 31:17 have no direct effect.
- R3: On a write at word offset 1, a 1 in written bit 14 also clears pending bit 31, exactly as if bit 31 had been written as 1.
- R4: A write at word offset 2 sets each pending bit in positions 31:17 whose written bit is 1. Other written bits are dropped.
- R5: Bus writes never change bits 15:0. Bits 16 and 0 of the pending word always read as zero.
- R6: `swLevels` always equals pending bits 31:16. It is updated in the same cycle as `pendWord`.
- R7: While `timerIn` is high, the pending bit at position `TIMER_BIT` (default 10, legal range 1..15) is set. In the cycle after `timerIn` is first seen low, that bit is cleared.
- R8: While `rst_n` is low, the pending word and `swLevels` are zero.
- R9: Writes at word offsets 0 and 3 leave the pending word unchanged.
- R10: A 1 in bit n (n in 15..1) of `hwLevelSet` sets pending bit n, and a 1 in `hwLevelClr` clears it. Bit 0 of both strobes is ignored. When set and clear hit the same bit, set wins. The timer rule of R7 is applied last and wins over both strobes at its position.
- R11: Every update appears on `pendWord` at the rising clock edge that samples the strobe. Bus, hardware and timer updates in one cycle are merged bit by bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| timerIn | input | 1 | Local timer request level |
| hwLevelSet | input | 16 | Hardware level set strobes (bit 0 unused) |
| hwLevelClr | input | 16 | Hardware level clear strobes (bit 0 unused) |
| busAddr | input | ADDR_W (2) | Word offset into the register window |
| busWrEn | input | 1 | Write strobe |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data for `busAddr` |
| pendWord | output | 32 | Raw pending word |
| swLevels | output | 16 | Software requests as a level vector |

## Verification
The clear port is driven with several data patterns:
- A single low software bit shows that a 1 clears only its own position.
- Bit 14 alone shows the alias onto bit 31, apart from any direct clear.
- All ones shows that the hardware field survives a full clear.

Hardware strobes hit disjoint bits, then the same bit at once, to resolve the set-wins rule. The timer is held high against a clear strobe at its position and is then dropped, to show that it wins and that it falls. A final cycle merges a bus set, a hardware set and a timer rise, which shows that no source masks another.

// File: rtl/intpend_pkg.sv
package intpend_pkg;
  localparam int WORD_W = 32;
  localparam int HALF_W = 16;

  // Strobes from the control path to the pending-word datapath.
  typedef struct packed {
    logic [WORD_W-1:0] swClrMask;
    logic [WORD_W-1:0] swSetMask;
    logic [HALF_W-1:0] hwSet;
    logic [HALF_W-1:0] hwClr;
    logic              timerSet;
    logic              timerClr;
  } pendStrb_t;
endpackage

// File: rtl/intpend_ctrl.sv
module intpend_ctrl
  import intpend_pkg::*;
#(
  parameter int ADDR_W    = 2,
  parameter int CLR_OFS   = 1,
  parameter int SET_OFS   = 2,
  parameter int SW_LO     = 17,
  parameter int ALIAS_SRC = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              timerIn,
  input  logic [HALF_W-1:0] hwLevelSet,
  input  logic [HALF_W-1:0] hwLevelClr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [WORD_W-1:0] busWrData,
  output pendStrb_t         strb
);
  localparam logic [WORD_W-1:0] SW_MASK = ~((WORD_W'(1) << SW_LO) - WORD_W'(1));
  localparam logic [HALF_W-1:0] HW_MASK = ~HALF_W'(1);

  logic timerPrev;
  logic clrHit;
  logic setHit;
  logic [WORD_W-1:0] clrRaw;

  always_ff @(posedge clk) begin
    if (!rst_n) timerPrev <= 1'b0;
    else        timerPrev <= timerIn;
  end

  assign clrHit = busWrEn && (busAddr == ADDR_W'(CLR_OFS));
  assign setHit = busWrEn && (busAddr == ADDR_W'(SET_OFS));

  always_comb begin
    clrRaw = busWrData;
    if (busWrData[ALIAS_SRC]) clrRaw[WORD_W-1] = 1'b1;
  end

  always_comb begin
    strb.swClrMask = clrHit ? (clrRaw & SW_MASK) : '0;
    strb.swSetMask = setHit ? (busWrData & SW_MASK) : '0;
    strb.hwSet     = hwLevelSet & HW_MASK;
    strb.hwClr     = hwLevelClr & HW_MASK;
    strb.timerSet  = timerIn;
    strb.timerClr  = !timerIn && timerPrev;
  end

  // R3: the alias bit on a clear write must reach bit 31 of the clear mask
  p_alias_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busWrEn && busAddr == ADDR_W'(CLR_OFS) && busWrData[ALIAS_SRC]) |-> strb.swClrMask[WORD_W-1]);

  // R9: writes to other offsets produce no software strobes
  p_unused_ofs_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busAddr != ADDR_W'(CLR_OFS) && busAddr != ADDR_W'(SET_OFS)) |-> (strb.swClrMask == '0 && strb.swSetMask == '0));

  // R7: a fall is flagged only one cycle after the line was high
  p_timer_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    strb.timerClr |-> ($past(timerIn) && !timerIn));
endmodule

// File: rtl/intpend_dp.sv
module intpend_dp
  import intpend_pkg::*;
#(
  parameter int ADDR_W    = 2,
  parameter int TIMER_BIT = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  pendStrb_t         strb,
  input  logic [ADDR_W-1:0] busAddr,
  output logic [WORD_W-1:0] busRdData,
  output logic [WORD_W-1:0] pendWord,
  output logic [HALF_W-1:0] swLevels
);
  logic [WORD_W-1:0] pendQ;
  logic [WORD_W-1:0] pendNext;

  always_comb begin
    pendNext = pendQ;
    pendNext = pendNext & ~strb.swClrMask;
    pendNext = pendNext | strb.swSetMask;
    pendNext[HALF_W-1:0] = (pendNext[HALF_W-1:0] & ~strb.hwClr) | strb.hwSet;
    if (strb.timerSet)      pendNext[TIMER_BIT] = 1'b1;
    else if (strb.timerClr) pendNext[TIMER_BIT] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pendQ <= '0;
    else        pendQ <= pendNext;
  end

  for (genvar i = 0; i < HALF_W; i++) begin : g_lvl
    assign swLevels[i] = pendQ[HALF_W + i];
  end

  assign pendWord  = pendQ;
  assign busRdData = (busAddr == '0) ? pendQ : '0;

  // R4: every requested software set bit is pending afterwards
  p_sw_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.swSetMask != '0) |=> ((pendQ & $past(strb.swSetMask)) == $past(strb.swSetMask)));

  // R2: every requested software clear bit is gone afterwards
  p_sw_clr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.swClrMask != '0) |=> ((pendQ & $past(strb.swClrMask)) == '0));

  // R5: without hardware or timer activity the low half holds
  p_hw_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.hwSet == '0 && strb.hwClr == '0 && !strb.timerSet && !strb.timerClr)
      |=> $stable(pendQ[HALF_W-1:0]));

  // R7: timer high leaves its bit set
  p_timer_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    strb.timerSet |=> pendQ[TIMER_BIT]);
endmodule

// File: rtl/intpend_top.sv
module intpend_top
  import intpend_pkg::*;
#(
  parameter int ADDR_W    = 2,
  parameter int TIMER_BIT = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              timerIn,
  input  logic [15:0]       hwLevelSet,
  input  logic [15:0]       hwLevelClr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [31:0]       busWrData,
  output logic [31:0]       busRdData,
  output logic [31:0]       pendWord,
  output logic [15:0]       swLevels
);
  pendStrb_t strb;

  intpend_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .timerIn(timerIn),
    .hwLevelSet(hwLevelSet), .hwLevelClr(hwLevelClr),
    .busAddr(busAddr), .busWrEn(busWrEn), .busWrData(busWrData),
    .strb(strb)
  );

  intpend_dp #(.ADDR_W(ADDR_W), .TIMER_BIT(TIMER_BIT)) u_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb), .busAddr(busAddr),
    .busRdData(busRdData), .pendWord(pendWord), .swLevels(swLevels)
  );

  // R5: bits 16 and 0 never become pending
  p_fixed_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pendWord[16] == 1'b0 && pendWord[0] == 1'b0));
endmodule

// File: tb/intpend_top_test.sv
module intpend_top_test;
  localparam int TB = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        timerIn = 1'b0;
  logic [15:0] hwLevelSet = '0;
  logic [15:0] hwLevelClr = '0;
  logic [1:0]  busAddr = '0;
  logic        busWrEn = 1'b0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic [31:0] pendWord;
  logic [15:0] swLevels;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  logic [31:0] model = '0;
  logic        tPrev = 1'b0;
  logic [31:0] expQ[$];
  string       tagQ[$];

  intpend_top uut (
    .clk(clk), .rst_n(rst_n), .timerIn(timerIn),
    .hwLevelSet(hwLevelSet), .hwLevelClr(hwLevelClr),
    .busAddr(busAddr), .busWrEn(busWrEn), .busWrData(busWrData),
    .busRdData(busRdData), .pendWord(pendWord), .swLevels(swLevels)
  );

  always #5 clk = ~clk;

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // Monitor: compare each registered result against the queued expectation.
  always @(negedge clk) begin
    if (expQ.size() > 0) begin
      logic [31:0] e;
      string t;
      e = expQ.pop_front();
      t = tagQ.pop_front();
      checks++;
      if (pendWord !== e || swLevels !== e[31:16]) begin
        failures++;
        $display("FAIL %s pendWord=%h swLevels=%h expected %h/%h", t, pendWord, swLevels, e, e[31:16]);
      end
    end
  end

  // Driver: apply one cycle of stimulus, update the reference model, queue result.
  task automatic step(input logic [1:0] a, input logic we, input logic [31:0] wd,
                      input logic [15:0] hs, input logic [15:0] hc, input logic tm,
                      input string tag);
    logic [31:0] n, cm;
    @(negedge clk);
    busAddr = a; busWrEn = we; busWrData = wd;
    hwLevelSet = hs; hwLevelClr = hc; timerIn = tm;
    n = model;
    cm = wd & 32'hFFFE0000;
    if (wd[14]) cm[31] = 1'b1;
    if (we && a == 2'd1) n = n & ~cm;
    if (we && a == 2'd2) n = n | (wd & 32'hFFFE0000);
    n[15:0] = (n[15:0] & ~(hc & 16'hFFFE)) | (hs & 16'hFFFE);
    if (tm) n[10] = 1'b1;
    else if (tPrev) n[10] = 1'b0;
    tPrev = tm;
    model = n;
    @(posedge clk);
    #1;
    expQ.push_back(n);
    tagQ.push_back(tag);
    busWrEn = 1'b0; hwLevelSet = '0; hwLevelClr = '0;
  endtask

  task automatic idle(input string tag);
    step(2'd0, 1'b0, 32'h0, 16'h0, 16'h0, timerIn, tag);
  endtask

  task automatic readCheck(input logic [1:0] a, input logic [31:0] e, input string tag);
    @(negedge clk);
    busAddr = a;
    #1;
    checks++;
    if (busRdData !== e) begin
      failures++;
      $display("FAIL %s read ofs %0d got %h expected %h", tag, a, busRdData, e);
    end
  endtask

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog expired got running expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (pendWord !== 32'h0 || swLevels !== 16'h0) begin
      failures++;
      $display("FAIL R8 in reset got %h expected 00000000", pendWord);
    end
    rst_n = 1'b1;
    idle("R8 after reset");
    readCheck(2'd0, 32'h0, "R1 reset readback");

    step(2'd2, 1'b1, 32'hFFFFFFFF, 0, 0, 0, "R4 R5 R6 set all");          // FFFE0000
    readCheck(2'd0, 32'hFFFE0000, "R1 offset 0");
    readCheck(2'd1, 32'h0, "R1 offset 1 zero");
    readCheck(2'd3, 32'h0, "R1 offset 3 zero");
    step(2'd1, 1'b1, 32'h00020000, 0, 0, 0, "R2 clear bit 17");           // FFFC0000
    step(2'd1, 1'b1, 32'h00004000, 0, 0, 0, "R3 alias clears 31");        // 7FFC0000
    step(2'd0, 1'b0, 32'h0, 16'h8003, 0, 0, "R10 hw set 15,1");           // 7FFC8002
    step(2'd1, 1'b1, 32'hFFFFFFFF, 0, 0, 0, "R2 R5 clear all sw");        // 00008002
    step(2'd3, 1'b1, 32'hFFFFFFFF, 0, 0, 0, "R9 offset 3 ignored");
    step(2'd0, 1'b1, 32'hFFFFFFFF, 0, 0, 0, "R9 offset 0 ignored");
    step(2'd0, 1'b0, 32'h0, 0, 0, 1, "R7 timer high");                    // 00008402
    step(2'd0, 1'b0, 32'h0, 0, 16'h0400, 1, "R10 timer beats clear");
    step(2'd0, 1'b0, 32'h0, 0, 0, 0, "R7 timer falls");                   // 00008002
    idle("R7 stays clear");
    step(2'd0, 1'b0, 32'h0, 16'h0010, 16'h0010, 0, "R10 set wins");       // 00008012
    step(2'd0, 1'b0, 32'h0, 0, 16'h8001, 0, "R10 hw clear");              // 00000012
    step(2'd2, 1'b1, 32'h80000000, 16'h0004, 0, 1, "R11 merged update");  // 80000416
    readCheck(2'd0, 32'h80000416, "R1 R11 merged readback");
    step(2'd1, 1'b1, 32'h00004000, 0, 0, 1, "R3 R6 alias empties levels");// 00000416

    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    checks++;
    if (pendWord !== 32'h0 || swLevels !== 16'h0) begin
      failures++;
      $display("FAIL R8 mid-run reset got %h expected 00000000", pendWord);
    end
    timerIn = 1'b0; model = '0; tPrev = 1'b0;
    rst_n = 1'b1;
    idle("R8 R7 no stale timer fall");
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule